// File: doc/BRIEF.md
# Shadow-Tag Data Cache Miss Counter

This block watches a stream of data memory references and decides, for each one, whether a direct-mapped data cache of a given size would have hit or missed. It keeps only the tag side of such a cache: one tag and one valid bit per line, and no data. Every accepted reference bumps a 64-bit reference counter, and every modelled miss bumps a 64-bit miss counter. Software divides the two to get a miss rate.

The default model is a 64 KB cache with 32-byte lines, which gives 2048 entries. One reference can be accepted every clock cycle. The tag entry is looked up and rewritten within that same cycle, so back-to-back references to one line behave like a real cache would. Software reads the counters through a snapshot strobe. The strobe copies both live counts into holding registers on the same edge, so the pair always belongs together. A synchronous clear empties the model and zeroes the live counts. If the clear arrives together with the strobe, the snapshot keeps the values from before the clear.

Top module: `tsm_miss_profiler`

## Requirements
- R1: After the asynchronous reset, both snapshot outputs read zero. A snapshot taken before any reference also reads zero for both counts.
- R2: The entry index is the address bits [15:5]. The stored tag is the whole line address (the address shifted right by 5). Two addresses that differ only in bits [4:0] fall in the same line.
- R3: Each accepted reference adds exactly one to the 64-bit reference count, whether it hits or misses.
- R4: A reference misses when its entry is invalid or when the stored tag differs from its line address. A miss adds one to the miss count and writes the new line address into the entry. A hit changes neither the miss count nor the entry.
- R5: After reset or clear, the first reference to any entry is a miss, whatever that entry held before.
- R6: Two addresses with the same index but a different line address evict each other. Alternating between them misses every time (for example 0x1000 and 0x11000).
- R7: References may arrive on consecutive cycles. An entry written by one reference is seen by a reference in the very next cycle.
- R8: `clr_i` is synchronous. It zeroes both live counts and invalidates every entry. A reference presented in the same cycle as `clr_i` is ignored.
- R9: `snap_i` loads both outputs on the same edge, with the live counts as they stood before that cycle's reference is counted. Without `snap_i`, the outputs hold their values.
- R10: When `snap_i` and `clr_i` arrive in the same cycle, the outputs receive the counts from before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | A reference is present this cycle |
| ref_addr_i | input | ADDR_W (32) | Byte address of the reference |
| clr_i | input | 1 | Synchronous clear of model and counts |
| snap_i | input | 1 | Copy both live counts to the outputs |
| ref_count_o | output | CNT_W (64) | Snapshotted reference count |
| miss_count_o | output | CNT_W (64) | Snapshotted miss count |

## Verification
The bench uses several kinds of address pattern, and each one separates a different fault:
- Same-line pairs that differ only in the byte offset show whether the offset bits are wrongly used in the index or the tag.
- Pairs exactly 64 KB apart share an index. They expose a tag that is truncated to the index width, and an entry that is never rewritten.
- A cold sweep over sixteen lines followed by a warm repeat shows that cold entries miss and warm entries hit.
- A pseudo-random stream confined to a few indexes and tags mixes hits, conflict misses and consecutive-cycle reuse, and is compared against an independent model at regular snapshots.
- Snapshots that coincide with a reference, with a clear, or with both show which cycle's counts each read returns.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lookup_e;

  localparam int unsigned CNT_REFS = 0;
  localparam int unsigned CNT_MISS = 1;
  localparam int unsigned NUM_CNT  = 2;
endpackage

// File: rtl/tsm_tag_store.sv
module tsm_tag_store #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CACHE_BYTES = 65536,
  parameter int unsigned LINE_BYTES  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lookup_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                flush_i,
  output tsm_pkg::lookup_e    result_o
);
  localparam int unsigned OFS_W   = $clog2(LINE_BYTES);
  localparam int unsigned ENTRIES = CACHE_BYTES / LINE_BYTES;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam int unsigned TAG_W   = ADDR_W - OFS_W;

  logic [TAG_W-1:0]   line;
  logic [IDX_W-1:0]   idx;
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic               upd;

  assign line = addr_i[ADDR_W-1:OFS_W];
  assign idx  = line[IDX_W-1:0];

  always_comb begin
    if (!lookup_i || flush_i)
      result_o = tsm_pkg::LK_IDLE;
    else if (vld_q[idx] && (tag_q[idx] == line))
      result_o = tsm_pkg::LK_HIT;
    else
      result_o = tsm_pkg::LK_MISS;
  end

  assign upd = (result_o == tsm_pkg::LK_MISS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q      <= '0;
    else if (flush_i) vld_q      <= '0;
    else if (upd)     vld_q[idx] <= 1'b1;
  end

  // tag array needs no reset: guarded by vld_q
  always_ff @(posedge clk_i) begin
    if (upd) tag_q[idx] <= line;
  end
endmodule

// File: rtl/tsm_counter.sv
module tsm_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    count_o <= '0;
    else if (clr_i) count_o <= '0;
    else if (inc_i) count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/tsm_snapshot.sv
module tsm_snapshot #(
  parameter int unsigned W = 64,
  parameter int unsigned N = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic [N-1:0][W-1:0] live_i,
  output logic [N-1:0][W-1:0] held_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     held_o[g] <= '0;
      else if (take_i) held_o[g] <= live_i[g];
    end
  end
endmodule

// File: rtl/tsm_miss_profiler.sv
module tsm_miss_profiler #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CACHE_BYTES = 65536,
  parameter int unsigned LINE_BYTES  = 32,
  parameter int unsigned CNT_W       = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_valid_i,
  input  logic [ADDR_W-1:0] ref_addr_i,
  input  logic              clr_i,
  input  logic              snap_i,
  output logic [CNT_W-1:0]  ref_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  import tsm_pkg::*;

  lookup_e                         lk_res;
  logic [NUM_CNT-1:0]              inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]   live_cnt;
  logic [NUM_CNT-1:0][CNT_W-1:0]   held_cnt;

  tsm_tag_store #(
    .ADDR_W     (ADDR_W),
    .CACHE_BYTES(CACHE_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) i_tags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lookup_i(ref_valid_i),
    .addr_i  (ref_addr_i),
    .flush_i (clr_i),
    .result_o(lk_res)
  );

  assign inc[CNT_REFS] = (lk_res != LK_IDLE);
  assign inc[CNT_MISS] = (lk_res == LK_MISS);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tsm_counter #(.W(CNT_W)) i_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .inc_i  (inc[g]),
      .count_o(live_cnt[g])
    );
  end

  tsm_snapshot #(.W(CNT_W), .N(NUM_CNT)) i_snap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(snap_i),
    .live_i(live_cnt),
    .held_o(held_cnt)
  );

  assign ref_count_o  = held_cnt[CNT_REFS];
  assign miss_count_o = held_cnt[CNT_MISS];
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned CNT_W      = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ref_valid_i,
  input logic [ADDR_W-1:0] ref_addr_i,
  input logic              clr_i,
  input logic              snap_i,
  input logic [CNT_W-1:0]  ref_count_o,
  input logic [CNT_W-1:0]  miss_count_o,
  input logic [CNT_W-1:0]  refs_live_i,
  input logic [CNT_W-1:0]  miss_live_i,
  input tsm_pkg::lookup_e  res_i
);
  localparam int unsigned OFS_W = $clog2(LINE_BYTES);
  logic acc;
  assign acc = ref_valid_i && !clr_i;

  // R3
  ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> refs_live_i == $past(refs_live_i) + CNT_W'(1));

  // R4
  hit_no_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && res_i == tsm_pkg::LK_HIT) |=> $stable(miss_live_i));

  // R4
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && res_i == tsm_pkg::LK_MISS) |=> miss_live_i == $past(miss_live_i) + CNT_W'(1));

  // R7
  reuse_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && $past(acc) && ref_addr_i[ADDR_W-1:OFS_W] == $past(ref_addr_i[ADDR_W-1:OFS_W]))
    |-> res_i == tsm_pkg::LK_HIT);

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (refs_live_i == '0) && (miss_live_i == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_valid_i && !clr_i) |=> $stable(refs_live_i) && $stable(miss_live_i));

  // R9
  snap_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (ref_count_o == $past(refs_live_i)) && (miss_count_o == $past(miss_live_i)));

  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(ref_count_o) && $stable(miss_count_o));

  // R4
  miss_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_live_i <= refs_live_i);
endmodule

bind tsm_miss_profiler tsm_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
) i_tsm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_valid_i (ref_valid_i),
  .ref_addr_i  (ref_addr_i),
  .clr_i       (clr_i),
  .snap_i      (snap_i),
  .ref_count_o (ref_count_o),
  .miss_count_o(miss_count_o),
  .refs_live_i (live_cnt[0]),
  .miss_live_i (live_cnt[1]),
  .res_i       (lk_res)
);

// File: tb/test_tsm_miss_profiler.sv
module test_tsm_miss_profiler;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned CNT_W  = 64;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ref_valid_i = 1'b0;
  logic [ADDR_W-1:0] ref_addr_i = '0;
  logic              clr_i = 1'b0;
  logic              snap_i = 1'b0;
  logic [CNT_W-1:0]  ref_count_o;
  logic [CNT_W-1:0]  miss_count_o;

  tsm_miss_profiler i_tsm_miss_profiler (.*);

  always #5 clk_i = ~clk_i;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  // independent model: 2048 entries, index addr[15:5], tag addr>>5
  bit               m_vld [2048];
  logic [26:0]      m_tag [2048];
  longint unsigned  m_refs = 0;
  longint unsigned  m_miss = 0;

  longint unsigned  q_refs [$];
  longint unsigned  q_miss [$];
  string            q_req  [$];

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    foreach (m_vld[i]) m_vld[i] = 1'b0;
    m_refs = 0;
    m_miss = 0;
  endtask

  // one cycle of stimulus, driven at the falling edge
  task automatic cyc(bit v, logic [31:0] a, bit c, bit s, string req);
    ref_valid_i = v;
    ref_addr_i  = a;
    clr_i       = c;
    snap_i      = s;
    if (s) begin
      q_refs.push_back(m_refs);
      q_miss.push_back(m_miss);
      q_req.push_back(req);
    end
    if (c) model_clear();
    else if (v) begin
      m_refs++;
      if (!m_vld[a[15:5]] || m_tag[a[15:5]] != a[31:5]) begin
        m_miss++;
        m_vld[a[15:5]] = 1'b1;
        m_tag[a[15:5]] = a[31:5];
      end
    end
    @(negedge clk_i);
    ref_valid_i = 1'b0;
    clr_i       = 1'b0;
    snap_i      = 1'b0;
  endtask

  task automatic rd(string req);
    cyc(1'b0, '0, 1'b0, 1'b1, req);
  endtask

  // monitor: compare each snapshot after its edge
  always @(posedge clk_i) begin
    if (rst_ni && snap_i) begin
      #1;
      if (q_req.size() == 0) begin
        check("R9 unexpected snapshot", 1, 0);
      end else begin
        automatic string r = q_req.pop_front();
        check({r, " refs"}, ref_count_o, q_refs.pop_front());
        check({r, " miss"}, miss_count_o, q_miss.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    longint unsigned h_refs, h_miss;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 reset refs", ref_count_o, 0);
    check("R1 reset miss", miss_count_o, 0);
    rd("R1 first snapshot");

    // R2 R7: same line, offset differs, back-to-back
    cyc(1'b1, 32'h0000_1000, 1'b0, 1'b0, "R2");
    cyc(1'b1, 32'h0000_101F, 1'b0, 1'b0, "R7");
    rd("R2 R7 same line");

    // R6: same index, 64 KB apart
    cyc(1'b1, 32'h0001_1000, 1'b0, 1'b0, "R6");
    cyc(1'b1, 32'h0000_1000, 1'b0, 1'b0, "R6");
    cyc(1'b1, 32'h0001_1004, 1'b0, 1'b0, "R6");
    rd("R6 conflict");

    // R5 R4: cold sweep then warm repeat
    for (int i = 0; i < 16; i++) cyc(1'b1, 32'h0002_0000 + 32'(i * 32), 1'b0, 1'b0, "R5");
    rd("R5 cold sweep");
    for (int i = 0; i < 16; i++) cyc(1'b1, 32'h0002_0008 + 32'(i * 32), 1'b0, 1'b0, "R4");
    rd("R4 warm repeat");

    // R9 hold without snap
    h_refs = ref_count_o;
    h_miss = miss_count_o;
    cyc(1'b1, 32'h0003_0000, 1'b0, 1'b0, "R9");
    repeat (3) @(negedge clk_i);
    check("R9 hold refs", ref_count_o, h_refs);
    check("R9 hold miss", miss_count_o, h_miss);

    // R9: snapshot with a reference in the same cycle shows pre-reference counts
    cyc(1'b1, 32'h0003_4000, 1'b0, 1'b1, "R9 snap with ref");
    rd("R9 after ref");

    // R10 R8: snap with clear and an ignored reference
    cyc(1'b1, 32'h0000_1000, 1'b1, 1'b1, "R10 snap with clear");
    rd("R8 cleared, ref ignored");
    cyc(1'b1, 32'h0002_0000, 1'b0, 1'b0, "R5");
    rd("R5 miss after clear");

    // R3 R4 R7: pseudo-random stream over few indexes and tags
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {14'd0, lfsr[1:0], 8'd0, lfsr[4:2], lfsr[7:3]};
      cyc(lfsr[8] | lfsr[9], a, 1'b0, (n % 150) == 149, "R3 R4 random");
    end
    rd("R3 R4 random end");

    repeat (3) @(negedge clk_i);
    check("R9 queue drained", q_req.size(), 0);
    finish_run();
  end
endmodule